// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the register file of one DMA channel. It sits on a plain 32-bit memory-mapped bus and holds four words: a control/status word, a transfer address counter and two general-purpose auxiliary words. A separate bus master performs the actual memory transfers. That master reports each finished transfer back to this block, together with its byte length, and the block advances the address counter by that length.

Toward the attached peripheral controller the block drives two signals. One is a one-cycle reset pulse. The other is a DMA-enable level. It also takes the peripheral's interrupt level. It records that level as a pending status bit and forwards it to the system interrupt output only while the interrupt-enable bit is set. The interrupt output is re-evaluated on two kinds of event: a change of the peripheral level and a write to the control/status word.

Writes are qualified by `bus_sel` and `bus_we`. Reads are combinational from `bus_addr`, so the read data reflects the register state of the current cycle.

Top module: `dma_chan_regs`

## Requirements
- R1: The word is chosen by `bus_addr[3:2]`: 0 is the control/status word, 1 the address counter, 2 and 3 the auxiliary words. All other address bits are ignored. The auxiliary words read back exactly what was written.
- R2: After reset the control/status word reads 0xA0000000 and the other three words read 0. `irq_o`, `dma_en_o` and `periph_rst_o` are low.
- R3: On a control/status write, the bits under mask 0xFE000007 keep their value. Every other stored bit takes the written value, subject to R7 and R8.
- R4: A rising `periph_irq_i` sets pending (bit 0) at the edge where the new level is sampled. `irq_o` rises at that same edge only if interrupt enable (bit 4) is 1. `irq_o` is never high unless both bit 0 and bit 4 are 1.
- R5: A falling `periph_irq_i` while pending is 1 clears pending and drops `irq_o` at the same edge.
- R6: A control/status write with bit 4 set while pending is 1 raises `irq_o` one cycle later. A write with bit 4 clear lowers `irq_o` one cycle later.
- R7: A control/status write with bit 7 set makes `periph_rst_o` high for exactly the one cycle that follows.
- R8: A control/status write with bit 6 set and bit 7 clear stores bit 6 as 0.
- R9: `dma_en_o` takes the value of bit 9 from each control/status write and holds it between writes.
- R10: A write to the address counter sets the loaded flag (bit 26) of the control/status word.
- R11: A `xfer_done_i` cycle adds the zero-extended `xfer_len_i` to the address counter, modulo 2^32. Back-to-back strobes accumulate.
- R12: When a bus write to the address counter and `xfer_done_i` occur in the same cycle, the written value is stored and the length is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid |
| bus_we | input | 1 | 1 = write access |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| periph_irq_i | input | 1 | Interrupt level from the peripheral |
| irq_o | output | 1 | Gated interrupt output |
| periph_rst_o | output | 1 | One-cycle reset pulse to the peripheral |
| dma_en_o | output | 1 | DMA-enable level to the peripheral |
| xfer_done_i | input | 1 | One transfer finished this cycle |
| xfer_len_i | input | LEN_W | Byte length of the finished transfer |

## Verification
Every registered result here is due one clock edge after its cause. This covers a bus write, a sampled change of `periph_irq_i`, and a transfer strobe. The bench drives each stimulus just after a rising edge and lets one edge pass. It then queues the expected values, and the monitor compares them at the next falling edge, when the new state is settled and nothing else has moved. The reset pulse is checked high at the first falling edge and low at the second. Register contents are read through the combinational read port, with the address set in the same cycle as the queued item.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 4;
    localparam int SEL_W     = $clog2(NUM_WORDS);
    localparam int AUX_BASE  = 2;
    localparam int NUM_AUX   = NUM_WORDS - AUX_BASE;

    // control/status bit positions
    localparam int BIT_PEND   = 0;
    localparam int BIT_IEN    = 4;
    localparam int BIT_DRAIN  = 6;
    localparam int BIT_PRST   = 7;
    localparam int BIT_DMAEN  = 9;
    localparam int BIT_LOADED = 26;

    localparam logic [WORD_W-1:0] CSR_RO_MASK = 32'hFE00_0007;
    localparam logic [WORD_W-1:0] CSR_RESET   = 32'hA000_0000;

    typedef enum logic [SEL_W-1:0] {
        W_CSR  = 2'd0,
        W_ADDR = 2'd1,
        W_AUX0 = 2'd2,
        W_AUX1 = 2'd3
    } word_e;

    typedef struct packed {
        logic [WORD_W-1:0] csr;
        logic              irq;
        logic              dma_en;
        logic              prst;
        logic              irq_in;
    } csr_state_t;
endpackage

// File: rtl/dma_chan_decode.sv
`timescale 1ns/1ps
module dma_chan_decode
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_WORDS-1:0] wr_stb,
    output logic [SEL_W-1:0]     rd_idx
);
    logic unused_addr_bits;

    assign rd_idx           = bus_addr[SEL_W+1:2];
    assign unused_addr_bits = ^bus_addr;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_stb
        assign wr_stb[g] = bus_sel & bus_we & (rd_idx == SEL_W'(g));
    end
endmodule

// File: rtl/dma_chan_csr.sv
`timescale 1ns/1ps
module dma_chan_csr
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_csr,
    input  logic              wr_addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              periph_irq_i,
    output logic [WORD_W-1:0] csr_q,
    output logic              irq_o,
    output logic              dma_en_o,
    output logic              periph_rst_o
);
    csr_state_t        st_d, st_q;
    logic [WORD_W-1:0] wval;
    logic              irq_rise, irq_fall;

    assign irq_rise = periph_irq_i & ~st_q.irq_in;
    assign irq_fall = ~periph_irq_i & st_q.irq_in;

    always_comb begin
        st_d        = st_q;
        st_d.prst   = 1'b0;
        st_d.irq_in = periph_irq_i;
        wval        = wdata;

        // bus write: uses the state before this cycle
        if (wr_csr) begin
            if (wval[BIT_PRST]) begin
                st_d.prst = 1'b1;
            end else if (wval[BIT_DRAIN]) begin
                wval[BIT_DRAIN] = 1'b0;
            end
            if (wval[BIT_IEN]) begin
                if (st_q.csr[BIT_PEND]) begin
                    st_d.irq = 1'b1;
                end
            end else if (st_q.csr[BIT_PEND] || st_q.csr[BIT_IEN]) begin
                st_d.irq = 1'b0;
            end
            st_d.dma_en = wval[BIT_DMAEN];
            st_d.csr    = (st_q.csr & CSR_RO_MASK) | (wval & ~CSR_RO_MASK);
        end

        if (wr_addr) begin
            st_d.csr[BIT_LOADED] = 1'b1;
        end

        // peripheral level events: act on the post-write enable
        if (irq_rise) begin
            st_d.csr[BIT_PEND] = 1'b1;
            if (st_d.csr[BIT_IEN]) begin
                st_d.irq = 1'b1;
            end
        end else if (irq_fall && st_d.csr[BIT_PEND]) begin
            st_d.csr[BIT_PEND] = 1'b0;
            if (st_d.csr[BIT_IEN]) begin
                st_d.irq = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{csr: CSR_RESET, irq: 1'b0, dma_en: 1'b0, prst: 1'b0, irq_in: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign csr_q        = st_q.csr;
    assign irq_o        = st_q.irq;
    assign dma_en_o     = st_q.dma_en;
    assign periph_rst_o = st_q.prst;
endmodule

// File: rtl/dma_chan_addr_ctr.sv
`timescale 1ns/1ps
module dma_chan_addr_ctr
    import dma_chan_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              xfer_done_i,
    input  logic [LEN_W-1:0]  xfer_len_i,
    output logic [WORD_W-1:0] addr_q
);
    logic [WORD_W-1:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (wr_addr) begin
            addr_d = wdata;
        end else if (xfer_done_i) begin
            addr_d = addr_q + WORD_W'(xfer_len_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end
endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              periph_irq_i,
    output logic              irq_o,
    output logic              periph_rst_o,
    output logic              dma_en_o,
    input  logic              xfer_done_i,
    input  logic [LEN_W-1:0]  xfer_len_i
);
    logic [NUM_WORDS-1:0] wr_stb;
    logic [SEL_W-1:0]     rd_idx;
    logic [WORD_W-1:0]    csr_q;
    logic [WORD_W-1:0]    addr_q;
    logic [WORD_W-1:0]    aux_words [NUM_AUX];

    dma_chan_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .wr_stb   (wr_stb),
        .rd_idx   (rd_idx)
    );

    dma_chan_csr u_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_csr       (wr_stb[W_CSR]),
        .wr_addr      (wr_stb[W_ADDR]),
        .wdata        (bus_wdata),
        .periph_irq_i (periph_irq_i),
        .csr_q        (csr_q),
        .irq_o        (irq_o),
        .dma_en_o     (dma_en_o),
        .periph_rst_o (periph_rst_o)
    );

    dma_chan_addr_ctr #(.LEN_W(LEN_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_addr     (wr_stb[W_ADDR]),
        .wdata       (bus_wdata),
        .xfer_done_i (xfer_done_i),
        .xfer_len_i  (xfer_len_i),
        .addr_q      (addr_q)
    );

    for (genvar g = 0; g < NUM_AUX; g++) begin : g_aux
        logic [WORD_W-1:0] aux_d, aux_q;

        always_comb begin
            aux_d = aux_q;
            if (wr_stb[AUX_BASE+g]) begin
                aux_d = bus_wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                aux_q <= '0;
            end else begin
                aux_q <= aux_d;
            end
        end

        assign aux_words[g] = aux_q;
    end

    always_comb begin
        unique case (word_e'(rd_idx))
            W_CSR:   bus_rdata = csr_q;
            W_ADDR:  bus_rdata = addr_q;
            W_AUX0:  bus_rdata = aux_words[0];
            W_AUX1:  bus_rdata = aux_words[1];
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chan_regs_chk.sv
`timescale 1ns/1ps
module dma_chan_regs_chk #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              periph_irq_i,
    input logic              irq_o,
    input logic              periph_rst_o,
    input logic              dma_en_o,
    input logic              xfer_done_i,
    input logic [LEN_W-1:0]  xfer_len_i,
    input logic [31:0]       csr_q,
    input logic [31:0]       addr_q
);
    logic csr_wr, addr_wr;
    assign csr_wr  = bus_sel && bus_we && (bus_addr[3:2] == 2'd0);
    assign addr_wr = bus_sel && bus_we && (bus_addr[3:2] == 2'd1);

    p_ro_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> ((csr_q & 32'hFA00_0006) == ($past(csr_q) & 32'hFA00_0006)));

    p_irq_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (csr_q[0] && csr_q[4]));

    p_rise_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(periph_irq_i) |=> csr_q[0]);

    p_fall_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_irq_i) |=> (!csr_q[0] && !irq_o));

    p_ien_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && bus_wdata[4] && csr_q[0] && periph_irq_i) |=> irq_o);

    p_ien_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !bus_wdata[4]) |=> !irq_o);

    p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && bus_wdata[7]) |=> periph_rst_o);

    p_rst_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_wr && bus_wdata[7]) |=> !periph_rst_o);

    p_drain_strip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && !bus_wdata[7]) |=> !csr_q[6]);

    p_dma_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr |=> (dma_en_o == $past(bus_wdata[9])));

    p_dma_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr |=> $stable(dma_en_o));

    p_loaded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> csr_q[26]);

    p_addr_inc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done_i && !addr_wr) |=> (addr_q == $past(addr_q) + 32'($past(xfer_len_i))));

    p_wr_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> (addr_q == $past(bus_wdata)));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .periph_irq_i (periph_irq_i),
    .irq_o        (irq_o),
    .periph_rst_o (periph_rst_o),
    .dma_en_o     (dma_en_o),
    .xfer_done_i  (xfer_done_i),
    .xfer_len_i   (xfer_len_i),
    .csr_q        (csr_q),
    .addr_q       (addr_q)
);

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;
    localparam int K_RD   = 0;
    localparam int K_IRQ  = 1;
    localparam int K_DEN  = 2;
    localparam int K_PRST = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        periph_irq_i, irq_o, periph_rst_o, dma_en_o;
    logic        xfer_done_i;
    logic [15:0] xfer_len_i;

    always #5 clk = ~clk;

    dma_chan_regs #(.ADDR_W(8), .LEN_W(16)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .periph_irq_i (periph_irq_i),
        .irq_o        (irq_o),
        .periph_rst_o (periph_rst_o),
        .dma_en_o     (dma_en_o),
        .xfer_done_i  (xfer_done_i),
        .xfer_len_i   (xfer_len_i)
    );

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad   = 0;
    bit    finished = 1'b0;

    // monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_IRQ:   act = {31'd0, irq_o};
                K_DEN:   act = {31'd0, dma_en_o};
                default: act = {31'd0, periph_rst_o};
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        step();
        bus_sel = 1'b0;
        bus_we  = 1'b0;
    endtask

    task automatic exp_sig(input int k, input logic e, input string tag);
        item_t it;
        it.kind = k;
        it.exp  = {31'd0, e};
        it.tag  = tag;
        q.push_back(it);
    endtask

    task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.kind  = K_RD;
        it.exp   = e;
        it.tag   = tag;
        q.push_back(it);
        step();
    endtask

    task automatic set_irq(input logic v);
        periph_irq_i = v;
        step();
    endtask

    task automatic xfer(input logic [15:0] len);
        xfer_done_i = 1'b1;
        xfer_len_i  = len;
        step();
        xfer_done_i = 1'b0;
        xfer_len_i  = '0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        bus_sel      = 1'b0;
        bus_we       = 1'b0;
        bus_addr     = '0;
        bus_wdata    = '0;
        periph_irq_i = 1'b0;
        xfer_done_i  = 1'b0;
        xfer_len_i   = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        step();

        // R2: reset state
        exp_sig(K_IRQ, 1'b0, "R2 irq_o");
        exp_sig(K_DEN, 1'b0, "R2 dma_en_o");
        exp_sig(K_PRST, 1'b0, "R2 periph_rst_o");
        exp_rd(8'h00, 32'hA000_0000, "R2 csr");
        exp_rd(8'h04, 32'h0, "R2 addr");
        exp_rd(8'h08, 32'h0, "R2 aux0");
        exp_rd(8'h0C, 32'h0, "R2 aux1");

        // R1: word select, high address bits ignored
        wr(8'h08, 32'h1234_5678);
        wr(8'h3C, 32'hCAFE_F00D);
        exp_rd(8'h48, 32'h1234_5678, "R1 aux0 alias");
        exp_rd(8'h0C, 32'hCAFE_F00D, "R1 aux1");

        // R3 / R9: read-only bits kept, enable level follows bit 9
        wr(8'h00, 32'h5A5A_5A1F);
        exp_sig(K_DEN, 1'b1, "R9 dma_en high");
        exp_sig(K_IRQ, 1'b0, "R6 no pending no irq");
        exp_rd(8'h00, 32'hA05A_5A18, "R3 ro mask");
        wr(8'h00, 32'h0);
        exp_sig(K_DEN, 1'b0, "R9 dma_en low");
        exp_rd(8'h00, 32'hA000_0000, "R3 clear writable");

        // R8: drain bit stripped
        wr(8'h00, 32'h0000_0040);
        exp_sig(K_PRST, 1'b0, "R7 no pulse on drain");
        exp_rd(8'h00, 32'hA000_0000, "R8 drain stripped");

        // R7: reset pulse, one cycle
        wr(8'h00, 32'h0000_00C0);
        exp_sig(K_PRST, 1'b1, "R7 pulse high");
        step();
        exp_sig(K_PRST, 1'b0, "R7 pulse ends");
        exp_rd(8'h00, 32'hA000_00C0, "R7 stored bits");
        wr(8'h00, 32'h0);

        // R4 / R5 / R6: interrupt gating
        set_irq(1'b1);
        exp_sig(K_IRQ, 1'b0, "R4 masked rise");
        exp_rd(8'h00, 32'hA000_0001, "R4 pending set");
        wr(8'h00, 32'h0000_0010);
        exp_sig(K_IRQ, 1'b1, "R6 enable raises");
        exp_rd(8'h00, 32'hA000_0011, "R6 csr");
        set_irq(1'b0);
        exp_sig(K_IRQ, 1'b0, "R5 fall lowers");
        exp_rd(8'h00, 32'hA000_0010, "R5 pending cleared");
        set_irq(1'b1);
        exp_sig(K_IRQ, 1'b1, "R4 enabled rise");
        exp_rd(8'h00, 32'hA000_0011, "R4 csr");
        wr(8'h00, 32'h0);
        exp_sig(K_IRQ, 1'b0, "R6 disable lowers");
        exp_rd(8'h00, 32'hA000_0001, "R6 pending kept");
        set_irq(1'b0);
        exp_rd(8'h00, 32'hA000_0000, "R5 pending cleared masked");

        // R10: loaded flag
        wr(8'h04, 32'h0000_1000);
        exp_rd(8'h00, 32'hA400_0000, "R10 loaded");
        exp_rd(8'h04, 32'h0000_1000, "R10 addr");

        // R11: increments, back to back, wrap
        xfer(16'h0040);
        exp_rd(8'h04, 32'h0000_1040, "R11 single");
        xfer(16'h0004);
        xfer(16'h0008);
        exp_rd(8'h04, 32'h0000_104C, "R11 back to back");
        wr(8'h04, 32'hFFFF_FFF0);
        xfer(16'h0020);
        exp_rd(8'h04, 32'h0000_0010, "R11 wrap");

        // R12: bus write beats increment
        bus_sel     = 1'b1;
        bus_we      = 1'b1;
        bus_addr    = 8'h04;
        bus_wdata   = 32'h0000_2000;
        xfer_done_i = 1'b1;
        xfer_len_i  = 16'h0010;
        step();
        bus_sel     = 1'b0;
        bus_we      = 1'b0;
        xfer_done_i = 1'b0;
        exp_rd(8'h04, 32'h0000_2000, "R12 write wins");

        step();
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule